// File: doc/BRIEF.md
# Interrupt Pending Aggregator with Multi-Enable Qualification

This block takes a fixed set of level-sensitive interrupt sources and merges them into one interrupt request line for a processor. Each source is qualified by a group of enable inputs, such as mask bits, priority-field enables and group enables that other logic gathers. A source qualifies only when the number of its set enables matches a total fixed for that source at elaboration time. A qualified source whose level is high is pending. The block keeps a running count of pending sources and raises the processor request whenever that count is above zero.

For the interrupt acknowledge path, the block also reports the vector of the lowest-numbered pending source. It qualifies that vector with a valid flag, which stays low when the processor's interrupt mask level is all ones. Source number 0 is reserved and has no effect. Per-source vectors and required enable totals are packed parameters.

Top module: `intc_agg_top`

## Requirements
- R1: Each source's enable count is the number of set bits among its NUM_EN enable inputs (bits i*NUM_EN upward). The source is enabled only when that count equals its required total, taken from field i of SRC_REQ (bits i*ENC_W upward). One set bit more or fewer leaves it disabled.
- R2: Bit i of `pend_o` is 1 exactly when source i is asserted and enabled.
- R3: A high level marks an unasserted source as asserted, and a low level clears an asserted source. A level held high keeps the source asserted and does not change it again.
- R4: `pend_cnt_o` equals the number of pending sources. It rises or falls by the number of sources whose pending state changed.
- R5: `cpu_irq_o` is set when the pending count leaves zero and cleared when the count returns to zero. It stays high while the count is nonzero.
- R6: When `vec_valid_o` is 1, `vec_o` holds field k of SRC_VEC (bits k*VEC_W upward), where k is the lowest-index pending source.
- R7: When the mask level input is all ones (4'hF), `vec_valid_o` is 0 whatever is pending.
- R8: When no source is pending, `vec_valid_o` is 0.
- R9: Source 0 is never pending and never counted, whatever its level or enables.
- R10: A change of level or enables shows on `pend_o`, `pend_cnt_o` and `cpu_irq_o` two rising edges after the edge that samples it. It shows on `vec_valid_o`/`vec_o` three edges after that sample edge.
- R11: After synchronous reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl_i | input | NUM_SRC | Level of each interrupt source |
| src_en_i | input | NUM_SRC*NUM_EN | Enable bits, NUM_EN per source |
| imask_i | input | IMASK_W | Processor interrupt mask level |
| pend_o | output | NUM_SRC | Pending flag per source |
| pend_cnt_o | output | CNT_W | Number of pending sources |
| cpu_irq_o | output | 1 | Aggregate interrupt request |
| vec_valid_o | output | 1 | Qualifies vec_o |
| vec_o | output | VEC_W | Vector of the lowest pending source |

## Verification
The assertions assume that levels and enables are synchronous to `clk` and stable around the sampling edge. They also assume that each required total is at most NUM_EN, so that a source can be enabled at all. The stimulus changes inputs only at falling edges. It keeps the default totals, all between 1 and 3 with three enables per source, so random enable patterns regularly hit and miss each total. Source 0 is driven with arbitrary values throughout to exercise its exclusion.

// File: rtl/intc_agg_pkg.sv
package intc_agg_pkg;
  // width needed to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/intc_agg_slot.sv
module intc_agg_slot #(
  parameter int NUM_EN = 3,
  parameter int ENC_W  = 2,
  parameter logic [ENC_W-1:0] REQ = '0,
  parameter bit ACTIVE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lvl_i,
  input  logic [NUM_EN-1:0] en_i,
  output logic              pend_o,
  output logic              rise_o,
  output logic              fall_o
);
  generate
    if (ACTIVE) begin : g_live
      logic             asrt_q;
      logic [ENC_W-1:0] ecnt_q;
      logic [ENC_W-1:0] ecnt_nxt;
      logic             pend_q;
      logic             pend_nxt;

      always_comb begin
        ecnt_nxt = '0;
        for (int b = 0; b < NUM_EN; b++) ecnt_nxt = ecnt_nxt + ENC_W'(en_i[b]);
      end

      assign pend_nxt = asrt_q && (ecnt_q == REQ);

      always_ff @(posedge clk) begin
        if (rst) begin
          asrt_q <= 1'b0;
          ecnt_q <= '0;
          pend_q <= 1'b0;
        end else begin
          // only a real level change alters the asserted flag
          if (lvl_i && !asrt_q)      asrt_q <= 1'b1;
          else if (!lvl_i && asrt_q) asrt_q <= 1'b0;
          ecnt_q <= ecnt_nxt;
          pend_q <= pend_nxt;
        end
      end

      assign pend_o = pend_q;
      assign rise_o = pend_nxt && !pend_q;
      assign fall_o = !pend_nxt && pend_q;

      // R2
      pend_needs_asrt_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> $past(asrt_q));
      // R1
      pend_needs_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> ($past(ecnt_q) == REQ));
    end else begin : g_dead
      assign pend_o = 1'b0;
      assign rise_o = 1'b0;
      assign fall_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/intc_agg_counter.sv
module intc_agg_counter #(
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] fall_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt, inc, dec;
  logic             irq_q;

  always_comb begin
    inc = '0;
    dec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      inc = inc + CNT_W'(rise_i[i]);
      dec = dec + CNT_W'(fall_i[i]);
    end
    cnt_nxt = cnt_q + inc - dec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (cnt_q == '0 && cnt_nxt != '0)      irq_q <= 1'b1;
      else if (cnt_q != '0 && cnt_nxt == '0) irq_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(NUM_SRC));
  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> ($past(cnt_q) == '0));
  // R5
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (cnt_q != '0));
endmodule

// File: rtl/intc_agg_picker.sv
module intc_agg_picker #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 12,
  parameter int IMASK_W = 4,
  parameter logic [NUM_SRC*VEC_W-1:0] SRC_VEC = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [IMASK_W-1:0] imask_i,
  output logic               valid_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam logic [IMASK_W-1:0] MASK_ALL = '1;

  logic [VEC_W-1:0] pick_vec;
  logic             any;
  logic             valid_q;
  logic [VEC_W-1:0] vec_q;

  // scan downward so the lowest-index pending source wins
  always_comb begin
    pick_vec = '0;
    any      = 1'b0;
    for (int i = NUM_SRC - 1; i >= 1; i--) begin
      if (pend_i[i]) begin
        pick_vec = SRC_VEC[i*VEC_W +: VEC_W];
        any      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      valid_q <= any && (imask_i != MASK_ALL);
      vec_q   <= pick_vec;
    end
  end

  assign valid_o = valid_q;
  assign vec_o   = vec_q;

  // R7
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ($past(imask_i) != MASK_ALL));
  // R8
  valid_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ($past(pend_i) != '0));
endmodule

// File: rtl/intc_agg_top.sv
module intc_agg_top
  import intc_agg_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_EN  = 3,
  parameter int VEC_W   = 12,
  parameter int IMASK_W = 4,
  parameter int ENC_W   = cnt_width(NUM_EN),
  parameter int CNT_W   = cnt_width(NUM_SRC),
  parameter logic [NUM_SRC*ENC_W-1:0] SRC_REQ = 16'hB9E4,
  parameter logic [NUM_SRC*VEC_W-1:0] SRC_VEC = 96'h2E0_2C0_2A0_280_260_240_220_200
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        src_lvl_i,
  input  logic [NUM_SRC*NUM_EN-1:0] src_en_i,
  input  logic [IMASK_W-1:0]        imask_i,
  output logic [NUM_SRC-1:0]        pend_o,
  output logic [CNT_W-1:0]          pend_cnt_o,
  output logic                      cpu_irq_o,
  output logic                      vec_valid_o,
  output logic [VEC_W-1:0]          vec_o
);
  logic [NUM_SRC-1:0] pend, rise, fall;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
      intc_agg_slot #(
        .NUM_EN (NUM_EN),
        .ENC_W  (ENC_W),
        .REQ    (SRC_REQ[gi*ENC_W +: ENC_W]),
        .ACTIVE (gi != 0)
      ) slot_i (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (src_lvl_i[gi]),
        .en_i   (src_en_i[gi*NUM_EN +: NUM_EN]),
        .pend_o (pend[gi]),
        .rise_o (rise[gi]),
        .fall_o (fall[gi])
      );
    end
  endgenerate

  intc_agg_counter #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .rise_i (rise),
    .fall_i (fall),
    .cnt_o  (pend_cnt_o),
    .irq_o  (cpu_irq_o)
  );

  intc_agg_picker #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W),
    .IMASK_W (IMASK_W),
    .SRC_VEC (SRC_VEC)
  ) pick_i (
    .clk     (clk),
    .rst     (rst),
    .pend_i  (pend),
    .imask_i (imask_i),
    .valid_o (vec_valid_o),
    .vec_o   (vec_o)
  );

  assign pend_o = pend;

  // R4
  cnt_match_chk: assert property (@(posedge clk) disable iff (rst)
    pend_cnt_o == CNT_W'($countones(pend)));
  // R9
  src0_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pend[0]);
endmodule

// File: tb/intc_agg_top_tb_top.sv
`timescale 1ns/1ps
module intc_agg_top_tb_top;
  localparam int NS = 8;
  localparam int NE = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] lvl = '0;
  logic [NS*NE-1:0] en = '0;
  logic [3:0]    imask = '0;
  logic [NS-1:0] pend;
  logic [3:0]    cnt;
  logic          irq, vval;
  logic [11:0]   vec;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intc_agg_top dut_i (
    .clk(clk), .rst(rst), .src_lvl_i(lvl), .src_en_i(en), .imask_i(imask),
    .pend_o(pend), .pend_cnt_o(cnt), .cpu_irq_o(irq),
    .vec_valid_o(vval), .vec_o(vec)
  );

  function automatic int req_of(input int i);
    case (i)
      1: return 1; 2: return 2; 3: return 3; 4: return 1;
      5: return 2; 6: return 3; 7: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [11:0] vec_of(input int i);
    return 12'h200 + 12'(32 * i);
  endfunction

  function automatic logic [NS-1:0] calc_pend(input logic [NS-1:0] l,
                                              input logic [NS*NE-1:0] e);
    logic [NS-1:0] p = '0;
    for (int i = 1; i < NS; i++)
      if (l[i] && $countones(e[i*NE +: NE]) == req_of(i)) p[i] = 1'b1;
    return p;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string ctx);
    logic [NS-1:0] ep = calc_pend(lvl, en);
    int first = 0;
    for (int i = NS - 1; i >= 1; i--) if (ep[i]) first = i;
    check(pend == ep, {"R2 pend ", ctx}, pend, ep);
    check(cnt == 4'($countones(ep)), {"R4 count ", ctx}, cnt, $countones(ep));
    check(irq == (ep != 0), {"R5 irq ", ctx}, irq, ep != 0);
    if (ep == 0)
      check(vval == 1'b0, {"R8 valid ", ctx}, vval, 0);
    else if (imask == 4'hF)
      check(vval == 1'b0, {"R7 valid ", ctx}, vval, 0);
    else begin
      check(vval == 1'b1, {"R6 valid ", ctx}, vval, 1);
      check(vec == vec_of(first), {"R6 vector ", ctx}, vec, vec_of(first));
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(pend == 0 && cnt == 0 && irq == 0 && vval == 0 && vec == 0,
          "R11 reset", {pend, cnt, irq, vval}, 0);

    // R10 latency: source 1 needs one enable
    lvl[1] = 1'b1; en[NE*1 +: NE] = 3'b001;
    @(posedge clk); @(negedge clk);
    check(irq == 1'b0, "R10 irq early", irq, 0);
    @(posedge clk); @(negedge clk);
    check(irq == 1'b1 && pend[1], "R10 irq at two edges", irq, 1);
    check(vval == 1'b0, "R10 vector early", vval, 0);
    @(posedge clk); @(negedge clk);
    check(vval == 1'b1 && vec == vec_of(1), "R10 vector at three edges", vec, vec_of(1));

    // R3 level held high: no change
    settle();
    check(pend[1] && cnt == 1, "R3 held high", cnt, 1);

    // R1 one enable too many, then too few
    en[NE*1 +: NE] = 3'b011; settle();
    check(!pend[1], "R1 too many enables", pend[1], 0);
    lvl[3] = 1'b1; en[NE*3 +: NE] = 3'b011; settle();
    check(!pend[3], "R1 too few enables", pend[3], 0);
    en[NE*3 +: NE] = 3'b111; settle();
    check(pend[3], "R1 exact total", pend[3], 1);
    check_all("exact");

    // R3 low level clears
    lvl[3] = 1'b0; settle();
    check(!pend[3] && irq == 0, "R3 deassert", pend[3], 0);

    // R9 source 0 fully driven
    lvl = 8'h01; en = '1; settle();
    check(pend[0] == 0 && cnt == 0 && irq == 0, "R9 source zero", cnt, 0);

    // R6 lowest index wins with all pending
    lvl = '1;
    for (int i = 1; i < NS; i++) en[i*NE +: NE] = 3'((1 << req_of(i)) - 1);
    settle();
    check(cnt == 4'(NS - 1), "R4 all pending", cnt, NS - 1);
    check_all("all");

    // R7 mask all ones
    imask = 4'hF; settle();
    check(vval == 1'b0 && irq == 1'b1, "R7 mask full", vval, 0);
    check_all("masked");
    imask = 4'h3;

    // R6 highest index only
    lvl = 8'h80; settle();
    check(vval && vec == vec_of(7), "R6 highest only", vec, vec_of(7));

    // random patterns
    for (int it = 0; it < 300; it++) begin
      lvl = 8'($urandom);
      en = 24'($urandom);
      imask = ($urandom % 5 == 0) ? 4'hF : 4'($urandom % 15);
      if ($urandom % 3 == 0) @(negedge clk);
      settle();
      check_all("random");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule